// File: doc/BRIEF.md
# Shared Address/Data Bus to Memory Window Bridge

This block connects a processor whose low address byte and data byte share one set of lines to a small local memory. Early in each bus cycle the shared lines carry the low half of the address, marked by a high address-strobe pulse. Later in the same cycle they carry data. The bridge keeps the low address byte once the strobe drops. It joins that byte with the high byte, which is driven separately, and presents a stable 16-bit address for the rest of the cycle.

From the read and write strobes and the memory/I-O select line, it builds four separate active-low strobes: memory read, memory write, I/O read and I/O write. The top six address bits are compared against a base parameter to select a 1 KB window. A behavioural RAM of that size answers in the window. Its read data goes out through a pad output and enable pair, for the shared lines. The enable is raised only during a selected memory read.

The block runs on a system clock. The address strobe is sampled on each clock edge, and its capture path is flow-through. A memory write commits on the rising edge of the memory write strobe, observed at the clock.

Top module: `mbus_window_bridge`

## Requirements
- R1: After reset, with the address strobe low, the low byte of the address output is 8'h00.
- R2: While the address strobe `ale` is high, `addr_o[7:0]` follows `ad_i` in the same cycle. The value present at each rising clock edge is stored.
- R3: Once `ale` is low, `addr_o[7:0]` holds the byte stored at the last rising clock edge at which `ale` was high, whatever `ad_i` does.
- R4: `addr_o[15:8]` always equals the high address input `a_hi`.
- R5: `mem_rd_n` is low exactly when `rd_n` is low and `io_m` is 0. `io_rd_n` is low exactly when `rd_n` is low and `io_m` is 1.
- R6: `mem_wr_n` and `io_wr_n` follow the same rule as R5, using `wr_n` in place of `rd_n`.
- R7: `cs_o` is high exactly when `addr_o[15:10]` equals the base parameter, which is 6'b001000 by default (addresses 16'h2000 to 16'h23FF).
- R8: During a selected memory read, `ad_oe` is 1 and `ad_o` carries the byte stored at location `addr_o[9:0]`.
- R9: A memory write commits at the first rising clock edge at which `mem_wr_n` is sampled high, after having been sampled low on the previous edge, provided `cs_o` is high. It uses `addr_o[9:0]` and `ad_i` at that edge.
- R10: A write with `cs_o` low, or an I/O write (`io_m` = 1), leaves every memory location unchanged.
- R11: `ad_oe` is 0 during an I/O read and during any read outside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_hi | input | 8 | High address byte from the processor |
| ad_i | input | 8 | Shared lines as seen at the pad (address, then data) |
| ad_o | output | 8 | Read data toward the shared-line pad driver |
| ad_oe | output | 1 | Pad drive enable for `ad_o` |
| ale | input | 1 | Address strobe, high while the shared lines carry the low address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| io_m | input | 1 | 0 for a memory access, 1 for an I/O access |
| addr_o | output | 16 | Demultiplexed full address |
| cs_o | output | 1 | Window chip select, active high |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |

## Verification
The address path is tested with a new byte presented while the strobe is high, then with junk on the shared lines after it falls. This separates a true hold from a transparent path or from capture on the wrong edge.

All four combinations of read or write against memory or I/O are applied. This shows whether each strobe is gated by the select line and does not merely copy the raw strobe.

Addresses at both ends of the window and just outside it check the decode width and the base value. Full write-then-read cycles check where data lands. Aliased out-of-window writes and I/O writes to a live location show that a write which must be suppressed really leaves the stored byte alone.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
   typedef struct packed {
      logic mem_rd_n;
      logic mem_wr_n;
      logic io_rd_n;
      logic io_wr_n;
   } strobe_t;

   localparam logic IOM_MEMORY = 1'b0;
   localparam logic IOM_IO     = 1'b1;
endpackage

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
   parameter int  LO_W      = 8,
   parameter bit  FLOW_THRU = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ale,
   input  logic [LO_W-1:0] ad_i,
   output logic [LO_W-1:0] lo_addr
);
   generate
      if (LO_W < 1) begin : g_bad_width
         $error("mbus_addr_latch: LO_W must be at least 1");
      end
   endgenerate

   logic [LO_W-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (ale) begin
         lat_q <= ad_i;
      end
   end

   generate
      if (FLOW_THRU) begin : g_flow
         assign lo_addr = ale ? ad_i : lat_q;
      end else begin : g_reg
         assign lo_addr = lat_q;
      end
   endgenerate

   // R2: a byte seen while the strobe is high is stored at the edge
   assert_capture_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (lat_q == $past(ad_i)));

   // R3: with the strobe low over two edges the stored byte does not move
   assert_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!ale && $past(!ale)) |-> $stable(lat_q));
endmodule

// File: rtl/mbus_strobe_gen.sv
module mbus_strobe_gen
   import mbus_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    rd_n,
   input  logic    wr_n,
   input  logic    io_m,
   output strobe_t strb
);
   logic is_mem;
   logic is_io;

   assign is_mem = (io_m == IOM_MEMORY);
   assign is_io  = (io_m == IOM_IO);

   always_comb begin
      strb.mem_rd_n = ~(~rd_n & is_mem);
      strb.io_rd_n  = ~(~rd_n & is_io);
      strb.mem_wr_n = ~(~wr_n & is_mem);
      strb.io_wr_n  = ~(~wr_n & is_io);
   end

   // R5: memory and I/O read strobes are never active together
   assert_rd_excl_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(!strb.mem_rd_n && !strb.io_rd_n));

   // R6: memory and I/O write strobes are never active together
   assert_wr_excl_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !(!strb.mem_wr_n && !strb.io_wr_n));
endmodule

// File: rtl/mbus_chip_sel.sv
module mbus_chip_sel #(
   parameter int                 SEL_W = 6,
   parameter logic [SEL_W-1:0]   BASE  = 6'b001000
) (
   input  logic [SEL_W-1:0] sel_bits,
   output logic             cs
);
   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("mbus_chip_sel: SEL_W must be at least 1");
      end
   endgenerate

   assign cs = (sel_bits == BASE);
endmodule

// File: rtl/mbus_ram.sv
module mbus_ram #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs,
   input  logic          mem_rd_n,
   input  logic          mem_wr_n,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          drive
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_depth
         $error("mbus_ram: AW must lie between 1 and 12");
      end
   endgenerate

   logic [DW-1:0] cells [DEPTH];
   logic          wr_prev_n;
   logic          commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_prev_n <= 1'b1;
      end else begin
         wr_prev_n <= mem_wr_n;
      end
   end

   assign commit = ~wr_prev_n & mem_wr_n & cs;

   always_ff @(posedge clk) begin
      if (commit) begin
         cells[addr] <= wdata;
      end
   end

   assign drive = cs & ~mem_rd_n;
   assign rdata = drive ? cells[addr] : '0;

   // R9: a commit only follows a strobe that was active on the previous edge
   assert_commit_edge_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($past(!mem_wr_n) && mem_wr_n));
endmodule

// File: rtl/mbus_window_bridge.sv
module mbus_window_bridge
   import mbus_pkg::*;
#(
   parameter int HI_W   = 8,
   parameter int LO_W   = 8,
   parameter int WIN_AW = 10,
   parameter logic [HI_W+LO_W-WIN_AW-1:0] WIN_BASE = 6'b001000,
   parameter bit FLOW_THRU = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [HI_W-1:0]      a_hi,
   input  logic [LO_W-1:0]      ad_i,
   output logic [LO_W-1:0]      ad_o,
   output logic                 ad_oe,
   input  logic                 ale,
   input  logic                 rd_n,
   input  logic                 wr_n,
   input  logic                 io_m,
   output logic [HI_W+LO_W-1:0] addr_o,
   output logic                 cs_o,
   output logic                 mem_rd_n,
   output logic                 mem_wr_n,
   output logic                 io_rd_n,
   output logic                 io_wr_n
);
   localparam int ADDR_W = HI_W + LO_W;
   localparam int SEL_W  = ADDR_W - WIN_AW;

   generate
      if (WIN_AW >= ADDR_W) begin : g_bad_window
         $error("mbus_window_bridge: window must be smaller than the address space");
      end
   endgenerate

   logic [LO_W-1:0] lo_addr;
   strobe_t         strb;
   logic            cs;
   logic [LO_W-1:0] rdata;
   logic            drive;

   mbus_addr_latch #(.LO_W(LO_W), .FLOW_THRU(FLOW_THRU)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .ale    (ale),
      .ad_i   (ad_i),
      .lo_addr(lo_addr)
   );

   assign addr_o = {a_hi, lo_addr};

   mbus_strobe_gen u_strobe (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_n (rd_n),
      .wr_n (wr_n),
      .io_m (io_m),
      .strb (strb)
   );

   mbus_chip_sel #(.SEL_W(SEL_W), .BASE(WIN_BASE)) u_sel (
      .sel_bits(addr_o[ADDR_W-1:WIN_AW]),
      .cs      (cs)
   );

   mbus_ram #(.AW(WIN_AW), .DW(LO_W)) u_ram (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs      (cs),
      .mem_rd_n(strb.mem_rd_n),
      .mem_wr_n(strb.mem_wr_n),
      .addr    (addr_o[WIN_AW-1:0]),
      .wdata   (ad_i),
      .rdata   (rdata),
      .drive   (drive)
   );

   assign ad_o     = rdata;
   assign ad_oe    = drive;
   assign cs_o     = cs;
   assign mem_rd_n = strb.mem_rd_n;
   assign mem_wr_n = strb.mem_wr_n;
   assign io_rd_n  = strb.io_rd_n;
   assign io_wr_n  = strb.io_wr_n;

   // R8 / R11: pad drive only during a selected memory read
   assert_drive_memrd_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rd_n && !io_m && cs_o));

   // R11: an I/O read never drives the shared lines
   assert_no_io_drive_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && io_m) |-> !ad_oe);
endmodule

// File: tb/sim_mbus_window_bridge.sv
module sim_mbus_window_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  a_hi = 8'h20;
   logic [7:0]  ad_i = 8'h00;
   logic [7:0]  ad_o;
   logic        ad_oe;
   logic        ale = 1'b0;
   logic        rd_n = 1'b1;
   logic        wr_n = 1'b1;
   logic        io_m = 1'b0;
   logic [15:0] addr_o;
   logic        cs_o;
   logic        mem_rd_n, mem_wr_n, io_rd_n, io_wr_n;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbus_window_bridge u0 (
      .clk(clk), .rst_n(rst_n), .a_hi(a_hi), .ad_i(ad_i), .ad_o(ad_o),
      .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
      .addr_o(addr_o), .cs_o(cs_o), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
      .io_rd_n(io_rd_n), .io_wr_n(io_wr_n)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic io);
      @(negedge clk);
      a_hi = a[15:8]; ad_i = a[7:0]; ale = 1'b1; io_m = io;
      @(negedge clk);
      ale = 1'b0; ad_i = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      ad_i = 8'h5A; io_m = 1'b0;
   endtask

   task automatic bus_read(input logic [15:0] a, input logic io,
                           output logic [7:0] d, output logic oe,
                           output logic [15:0] seen);
      @(negedge clk);
      a_hi = a[15:8]; ad_i = a[7:0]; ale = 1'b1; io_m = io;
      @(negedge clk);
      ale = 1'b0; ad_i = 8'hC3; rd_n = 1'b0;
      #1;
      d = ad_o; oe = ad_oe; seen = addr_o;
      @(negedge clk);
      rd_n = 1'b1; io_m = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk(addr_o == 16'h2000, "R1 reset address", addr_o, 16'h2000);
      chk(ad_oe == 1'b0, "R1 no drive in reset state", ad_oe, 0);
   endtask

   task automatic t_latch;
      @(negedge clk);
      ale = 1'b1; ad_i = 8'h34;
      #1;
      chk(addr_o[7:0] == 8'h34, "R2 flow-through", addr_o[7:0], 8'h34);
      ad_i = 8'h56;
      #1;
      chk(addr_o[7:0] == 8'h56, "R2 follows change", addr_o[7:0], 8'h56);
      @(negedge clk);
      ale = 1'b0; ad_i = 8'h99;
      #1;
      chk(addr_o[7:0] == 8'h56, "R3 hold after strobe falls", addr_o[7:0], 8'h56);
      @(negedge clk);
      ad_i = 8'h0F;
      #1;
      chk(addr_o[7:0] == 8'h56, "R3 hold next cycle", addr_o[7:0], 8'h56);
      a_hi = 8'h7F;
      #1;
      chk(addr_o[15:8] == 8'h7F, "R4 high byte passes", addr_o[15:8], 8'h7F);
   endtask

   task automatic t_strobes;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         rd_n = k[0]; io_m = k[1]; wr_n = 1'b1;
         #1;
         chk(mem_rd_n == (k[0] | k[1]), "R5 mem read strobe", mem_rd_n, k[0] | k[1]);
         chk(io_rd_n == (k[0] | ~k[1]), "R5 io read strobe", io_rd_n, k[0] | ~k[1]);
         rd_n = 1'b1; wr_n = k[0];
         #1;
         chk(mem_wr_n == (k[0] | k[1]), "R6 mem write strobe", mem_wr_n, k[0] | k[1]);
         chk(io_wr_n == (k[0] | ~k[1]), "R6 io write strobe", io_wr_n, k[0] | ~k[1]);
      end
      @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1; io_m = 1'b0;
   endtask

   task automatic t_decode;
      logic [15:0] probe [5];
      logic        want  [5];
      probe[0] = 16'h2000; want[0] = 1'b1;
      probe[1] = 16'h23FF; want[1] = 1'b1;
      probe[2] = 16'h2400; want[2] = 1'b0;
      probe[3] = 16'h1FFF; want[3] = 1'b0;
      probe[4] = 16'hA000; want[4] = 1'b0;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         a_hi = probe[k][15:8]; ad_i = probe[k][7:0]; ale = 1'b1;
         @(negedge clk);
         ale = 1'b0; ad_i = 8'hEE;
         #1;
         chk(cs_o == want[k], "R7 window decode", {probe[k], 15'd0, cs_o}, {probe[k], 15'd0, want[k]});
      end
   endtask

   task automatic t_write_read;
      logic [7:0] d; logic oe; logic [15:0] seen;
      bus_write(16'h2005, 8'h3E, 1'b0);
      bus_write(16'h2006, 8'h32, 1'b0);
      bus_write(16'h23FF, 8'hA5, 1'b0);
      bus_read(16'h2005, 1'b0, d, oe, seen);
      chk(oe == 1'b1, "R8 drive enable on memory read", oe, 1);
      chk(d == 8'h3E, "R9 data at 2005", d, 8'h3E);
      chk(seen == 16'h2005, "R3 address held in data phase", seen, 16'h2005);
      bus_read(16'h2006, 1'b0, d, oe, seen);
      chk(d == 8'h32, "R9 data at 2006", d, 8'h32);
      bus_read(16'h23FF, 1'b0, d, oe, seen);
      chk(d == 8'hA5, "R8 data at window top", d, 8'hA5);
   endtask

   task automatic t_suppressed;
      logic [7:0] d; logic oe; logic [15:0] seen;
      bus_write(16'h2405, 8'h11, 1'b0);
      bus_read(16'h2005, 1'b0, d, oe, seen);
      chk(d == 8'h3E, "R10 unselected write ignored", d, 8'h3E);
      bus_write(16'h2006, 8'h77, 1'b1);
      bus_read(16'h2006, 1'b0, d, oe, seen);
      chk(d == 8'h32, "R10 io write ignored", d, 8'h32);
      bus_read(16'h2005, 1'b1, d, oe, seen);
      chk(oe == 1'b0, "R11 io read no drive", oe, 0);
      bus_read(16'h2405, 1'b0, d, oe, seen);
      chk(oe == 1'b0, "R11 unselected read no drive", oe, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_latch();
      t_strobes();
      t_decode();
      t_write_read();
      t_suppressed();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule